// File: doc/BRIEF.md
# Received Signal Strength Averager with Clear-Channel Decision

This block turns a stream of per-sample signal-strength estimates, already expressed in dB relative to one milliwatt, into a smoothed received-strength code. A leaky integrator smooths the samples. Its time constant is one symbol period (slow and steady) or a quarter of a symbol period (fast, with more variance), chosen by a single control bit.

A signed calibration offset is added to the smoothed value, and the sum is saturated into an 8-bit code. Code 0 stands for -127 dBm or below and code 127 for 0 dBm or above. The code is compared every cycle against a busy threshold to give a clear-channel verdict.

When the receive path signals the end of a packet or the end of a measurement window, a capture strobe freezes the code together with the frequency-correction and antenna values that accompany it. Those frozen values stay put until the next strobe. Computing magnitude from I/Q data, gain control and register access are handled elsewhere.

Top module: `rssi_cca_top`

## Requirements
- R1: On each cycle with `sample_valid` high, the internal average `A` (the sample scaled by 2^F, F = 8 fraction bits) becomes `A + ((sample·2^F − A) >>> k)`, using an arithmetic shift. k = log2(SPS) when `decay_fast` = 0 and log2(SPS) − 2 when `decay_fast` = 1. SPS defaults to 16, so k is 4 or 2.
- R2: While `sample_valid` is low, the average does not move and `rssi_live` keeps its value whatever `sample_db` carries.
- R3: `rssi_live` = clamp(floor(A/2^F + 1/2) + offset + 127, 0, 127). `cal_offset` is a 6-bit two's-complement value from -32 to +31, and `sample_db` is a 9-bit two's-complement dBm value.
- R4: `cca_busy` is 1 exactly when `rssi_live` is strictly greater than the threshold in use. A code equal to the threshold reads as clear, and a threshold of 0xFF never reports busy.
- R5: A `capture` pulse at a clock edge loads `rssi_cap`, `freq_cap` and `ant_cap` with the values `rssi_live`, `freq_in` and `ant_in` have at that edge. The loaded values are visible after that edge.
- R6: Between capture pulses, `rssi_cap`, `freq_cap` and `ant_cap` hold their values while the live inputs change.
- R7: Synchronous reset sets the average to -127 dBm. It sets `rssi_live`, `rssi_cap`, `freq_cap`, `ant_cap` and `cca_busy` to 0, and loads the configuration stage with threshold 0xFF, offset 0 and slow decay.
- R8: A sample accepted at one edge shows in `rssi_live` and `cca_busy` after the following edge, not before. The configuration inputs pass through one register before use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Qualifies `sample_db` |
| sample_db | input | 9 | Signal strength sample, two's-complement dBm |
| decay_fast | input | 1 | 0: one-symbol time constant, 1: quarter-symbol |
| cal_offset | input | 6 | Calibration offset, two's-complement dB |
| busy_thresh | input | 8 | Busy threshold code |
| capture | input | 1 | End-of-packet / end-of-measurement strobe |
| freq_in | input | 4 | Frequency correction to be captured |
| ant_in | input | 1 | Antenna index to be captured |
| rssi_live | output | 8 | Live saturated strength code |
| rssi_cap | output | 8 | Captured strength code |
| freq_cap | output | 4 | Captured frequency correction |
| ant_cap | output | 1 | Captured antenna index |
| cca_busy | output | 1 | Channel busy flag |

## Verification
The assertions assume that `sample_db` stays within its 9-bit two's-complement range. That range is what bounds the average between the scaled minimum and maximum sample. They also assume `capture` is only pulsed outside reset.

The stimulus changes `decay_fast`, `cal_offset` and `busy_thresh` only while samples are paused or at the start of a vector, and then holds them for hundreds of samples so that the average settles. Single-sample step tests run from the reset average with fixed configuration, so the intermediate code can be predicted exactly from the update rule.

// File: rtl/rssi_pkg.sv
package rssi_pkg;
  localparam int CODE_W    = 8;
  localparam int CODE_MAX  = 127;
  localparam int FLOOR_DBM = -127;
  localparam int THR_RST   = 255;

  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/rssi_leaky_avg.sv
module rssi_leaky_avg
  import rssi_pkg::*;
#(
  parameter int SAMPLE_W = 9,
  parameter int FRAC_W   = 8,
  parameter int SPS      = 16,
  localparam int AVG_W   = SAMPLE_W + FRAC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic                    decay_fast,
  output logic signed [AVG_W-1:0] acc
);
  localparam int K_SLOW  = $clog2(SPS);
  localparam int K_FAST  = (K_SLOW >= 2) ? K_SLOW - 2 : 0;
  localparam int SHIFT_W = $clog2(K_SLOW + 1) + 1;
  localparam logic signed [AVG_W-1:0] ACC_RST = AVG_W'(FLOOR_DBM * (2 ** FRAC_W));
  localparam logic signed [AVG_W-1:0] ACC_MIN = AVG_W'(-(2 ** (SAMPLE_W - 1)) * (2 ** FRAC_W));
  localparam logic signed [AVG_W-1:0] ACC_MAX = AVG_W'((2 ** (SAMPLE_W - 1) - 1) * (2 ** FRAC_W));

  logic signed [AVG_W-1:0] x_ext;
  logic signed [AVG_W-1:0] diff;
  logic signed [AVG_W-1:0] step;
  logic [SHIFT_W-1:0]      k_sel;

  // Two shift variants: a design with too few samples per symbol keeps one constant
  generate
    if (K_SLOW == K_FAST) begin : g_single_k
      assign k_sel = SHIFT_W'(K_SLOW);
    end else begin : g_dual_k
      assign k_sel = decay_fast ? SHIFT_W'(K_FAST) : SHIFT_W'(K_SLOW);
    end
  endgenerate

  always_comb begin
    x_ext = $signed({sample[SAMPLE_W-1], sample, {FRAC_W{1'b0}}});
    diff  = x_ext - acc;
    step  = diff >>> k_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= ACC_RST;
    end else if (sample_valid) begin
      acc <= acc + step;
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(acc)); // R2
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (acc >= ACC_MIN) && (acc <= ACC_MAX)); // R1
endmodule

// File: rtl/rssi_code_calc.sv
module rssi_code_calc
  import rssi_pkg::*;
#(
  parameter int AVG_W  = 18,
  parameter int FRAC_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [AVG_W-1:0] acc,
  input  logic signed [OFF_W-1:0] cal_off,
  input  code_t                   thresh,
  output code_t                   code_q,
  output logic                    busy_q
);
  localparam logic signed [AVG_W-1:0] HALF  = AVG_W'(2 ** (FRAC_W - 1));
  localparam logic signed [AVG_W-1:0] BIAS  = AVG_W'(-FLOOR_DBM);
  localparam logic signed [AVG_W-1:0] TOP   = AVG_W'(CODE_MAX);

  logic signed [AVG_W-1:0] rounded;
  logic signed [AVG_W-1:0] off_ext;
  logic signed [AVG_W-1:0] sum;
  code_t                   code_d;
  logic                    busy_d;

  always_comb begin
    rounded = (acc + HALF) >>> FRAC_W;
    off_ext = $signed({{(AVG_W - OFF_W){cal_off[OFF_W-1]}}, cal_off});
    sum     = rounded + off_ext + BIAS;
    if (sum < 0) begin
      code_d = '0;
    end else if (sum > TOP) begin
      code_d = code_t'(CODE_MAX);
    end else begin
      code_d = sum[CODE_W-1:0];
    end
    busy_d = (code_d > thresh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      busy_q <= 1'b0;
    end else begin
      code_q <= code_d;
      busy_q <= busy_d;
    end
  end

  AST_CODE_CEIL: assert property (@(posedge clk) disable iff (rst)
    code_q <= code_t'(CODE_MAX)); // R3
endmodule

// File: rtl/rssi_capture.sv
module rssi_capture
  import rssi_pkg::*;
#(
  parameter int FREQ_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  code_t             live_code,
  input  logic [FREQ_W-1:0] freq_in,
  input  logic              ant_in,
  output code_t             cap_code,
  output logic [FREQ_W-1:0] cap_freq,
  output logic              cap_ant
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_code <= '0;
      cap_freq <= '0;
      cap_ant  <= 1'b0;
    end else if (capture) begin
      cap_code <= live_code;
      cap_freq <= freq_in;
      cap_ant  <= ant_in;
    end
  end

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
    capture |=> (cap_code == $past(live_code)) && (cap_freq == $past(freq_in))); // R5
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(cap_code) && $stable(cap_freq) && $stable(cap_ant)); // R6
endmodule

// File: rtl/rssi_cca_top.sv
module rssi_cca_top
  import rssi_pkg::*;
#(
  parameter int SAMPLE_W = 9,
  parameter int FRAC_W   = 8,
  parameter int SPS      = 16,
  parameter int OFF_W    = 6,
  parameter int FREQ_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample_db,
  input  logic                decay_fast,
  input  logic [OFF_W-1:0]    cal_offset,
  input  logic [7:0]          busy_thresh,
  input  logic                capture,
  input  logic [FREQ_W-1:0]   freq_in,
  input  logic                ant_in,
  output logic [7:0]          rssi_live,
  output logic [7:0]          rssi_cap,
  output logic [FREQ_W-1:0]   freq_cap,
  output logic                ant_cap,
  output logic                cca_busy
);
  localparam int AVG_W = SAMPLE_W + FRAC_W + 1;

  // Configuration stage: one register between the field inputs and their use
  logic                    decay_q;
  logic signed [OFF_W-1:0] off_q;
  code_t                   thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      decay_q <= 1'b0;
      off_q   <= '0;
      thr_q   <= code_t'(THR_RST);
    end else begin
      decay_q <= decay_fast;
      off_q   <= $signed(cal_offset);
      thr_q   <= busy_thresh;
    end
  end

  logic signed [AVG_W-1:0] acc;
  code_t                   live_code;
  logic                    busy;
  code_t                   cap_code;

  rssi_leaky_avg #(
    .SAMPLE_W (SAMPLE_W),
    .FRAC_W   (FRAC_W),
    .SPS      (SPS)
  ) avg_i (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .sample       ($signed(sample_db)),
    .decay_fast   (decay_q),
    .acc          (acc)
  );

  rssi_code_calc #(
    .AVG_W  (AVG_W),
    .FRAC_W (FRAC_W),
    .OFF_W  (OFF_W)
  ) calc_i (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .cal_off (off_q),
    .thresh  (thr_q),
    .code_q  (live_code),
    .busy_q  (busy)
  );

  rssi_capture #(
    .FREQ_W (FREQ_W)
  ) cap_i (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .live_code (live_code),
    .freq_in   (freq_in),
    .ant_in    (ant_in),
    .cap_code  (cap_code),
    .cap_freq  (freq_cap),
    .cap_ant   (ant_cap)
  );

  assign rssi_live = live_code;
  assign rssi_cap  = cap_code;
  assign cca_busy  = busy;

  AST_BUSY_STRICT: assert property (@(posedge clk) disable iff (rst)
    cca_busy |-> (rssi_live > $past(thr_q))); // R4
  AST_CLEAR_AT_MAX_THR: assert property (@(posedge clk) disable iff (rst)
    (thr_q == 8'hFF) |=> !cca_busy); // R4
endmodule

// File: tb/rssi_cca_top_tb.sv
module rssi_cca_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 300;
  localparam int NVEC       = 12;

  logic       clk = 1'b0;
  logic       rst;
  logic       sample_valid;
  logic [8:0] sample_db;
  logic       decay_fast;
  logic [5:0] cal_offset;
  logic [7:0] busy_thresh;
  logic       capture;
  logic [3:0] freq_in;
  logic       ant_in;
  logic [7:0] rssi_live;
  logic [7:0] rssi_cap;
  logic [3:0] freq_cap;
  logic       ant_cap;
  logic       cca_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rssi_cca_top dut_i (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .sample_db    (sample_db),
    .decay_fast   (decay_fast),
    .cal_offset   (cal_offset),
    .busy_thresh  (busy_thresh),
    .capture      (capture),
    .freq_in      (freq_in),
    .ant_in       (ant_in),
    .rssi_live    (rssi_live),
    .rssi_cap     (rssi_cap),
    .freq_cap     (freq_cap),
    .ant_cap      (ant_cap),
    .cca_busy     (cca_busy)
  );

  // {decay[32], offset[31:26], sample[25:17], thresh[16:9], exp_code[8:1], exp_busy[0]}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 6'(0),   9'(-60),  8'hFF, 8'd67,  1'b0},
    {1'b1, 6'(0),   9'(-60),  8'd66, 8'd67,  1'b1},
    {1'b1, 6'(0),   9'(-60),  8'd67, 8'd67,  1'b0},
    {1'b0, 6'(31),  9'(-20),  8'd126,8'd127, 1'b1},
    {1'b1, 6'(-32), 9'(-100), 8'd0,  8'd0,   1'b0},
    {1'b0, 6'(-32), 9'(-90),  8'd4,  8'd5,   1'b1},
    {1'b1, 6'(5),   9'(-127), 8'd5,  8'd5,   1'b0},
    {1'b0, 6'(0),   9'(40),   8'hFF, 8'd127, 1'b0},
    {1'b1, 6'(0),   9'(-200), 8'd0,  8'd0,   1'b0},
    {1'b0, 6'(10),  9'(0),    8'd127,8'd127, 1'b0},
    {1'b1, 6'(-1),  9'(-1),   8'd124,8'd125, 1'b1},
    {1'b0, 6'(17),  9'(-111), 8'd32, 8'd33,  1'b1}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic fast);
    @(negedge clk);
    rst          = 1'b1;
    sample_valid = 1'b0;
    sample_db    = '0;
    decay_fast   = fast;
    cal_offset   = '0;
    busy_thresh  = 8'hFF;
    capture      = 1'b0;
    freq_in      = '0;
    ant_in       = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_samples(input logic [8:0] s, input int n);
    sample_db    = s;
    sample_valid = 1'b1;
    repeat (n) @(negedge clk);
    sample_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_capture(input logic [3:0] f, input logic a);
    freq_in = f;
    ant_in  = a;
    capture = 1'b1;
    @(negedge clk);
    capture = 1'b0;
  endtask

  task automatic step_test(input logic fast, input int exp_code, input string req);
    do_reset(fast);
    sample_db    = 9'd0;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    check("R8", "live before second edge", int'(rssi_live), 0);
    @(negedge clk);
    check(req, "code after one sample step", int'(rssi_live), exp_code);
  endtask

  initial begin
    rst = 1'b1;
    // reset state
    do_reset(1'b0);
    check("R7", "live after reset", int'(rssi_live), 0);
    check("R7", "captured after reset", int'(rssi_cap), 0);
    check("R7", "busy after reset", int'(cca_busy), 0);
    check("R7", "freq/ant after reset", int'({freq_cap, ant_cap}), 0);

    // steady-state vector walk (R1 convergence, R3 mapping and saturation, R4 strict compare)
    for (int i = 0; i < NVEC; i++) begin
      decay_fast  = VEC[i][32];
      cal_offset  = VEC[i][31:26];
      busy_thresh = VEC[i][16:9];
      run_samples(VEC[i][25:17], SETTLE);
      check("R3", $sformatf("vector %0d code", i), int'(rssi_live), int'(VEC[i][8:1]));
      check("R4", $sformatf("vector %0d busy", i), int'(cca_busy), int'(VEC[i][0]));
    end

    // capture and hold
    do_reset(1'b1);
    run_samples(9'(-60), SETTLE);
    check("R3", "pre-capture live", int'(rssi_live), 67);
    pulse_capture(4'hA, 1'b1);
    check("R5", "captured code", int'(rssi_cap), 67);
    check("R5", "captured freq/ant", int'({freq_cap, ant_cap}), int'({4'hA, 1'b1}));
    freq_in = 4'h3;
    ant_in  = 1'b0;
    run_samples(9'(-20), SETTLE);
    check("R3", "live after move", int'(rssi_live), 107);
    check("R6", "captured code held", int'(rssi_cap), 67);
    check("R6", "captured freq/ant held", int'({freq_cap, ant_cap}), int'({4'hA, 1'b1}));
    pulse_capture(4'h3, 1'b0);
    check("R5", "recaptured code", int'(rssi_cap), 107);
    check("R5", "recaptured freq/ant", int'({freq_cap, ant_cap}), int'({4'h3, 1'b0}));

    // single-sample step from the reset floor: k=2 gives 32, k=4 gives 8
    step_test(1'b1, 32, "R1");
    // idle samples are ignored
    sample_db = 9'd100;
    repeat (6) @(negedge clk);
    check("R2", "live with valid low", int'(rssi_live), 32);
    step_test(1'b0, 8, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule